// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 128K words by 32 bits. The RAM is made of four byte-wide devices that share the address, the write-enable strobe and the output-enable strobe. Each device has its own active-low chip select. The controller accepts one word request at a time through a valid/ready handshake. It turns that request into a timed sequence of address, chip-select, write-enable and output-enable levels on the RAM pins. It drives the shared 32-bit data bus through separate write-data and drive-enable outputs, and it takes the RAM's read data on a separate input.

The RAM has no byte-enable pins. A partial write therefore lowers only the chip selects of the byte lanes named in the request's mask. Every phase (read access, write pulse, write recovery and the bus turnaround after a read) is a whole number of system clock cycles. That number is computed when the block is elaborated from the clock period and a speed-grade parameter: the nanosecond limit is divided by the clock period and rounded up, with a floor of one cycle. A read returns its word together with a one-cycle valid pulse.

Top module: `asram_ctl`

## Requirements
- R1: Out of reset, and whenever no request is in progress, `reqReady` is high, all four chip selects, `memWeN` and `memOeN` are high, `memDoutEn` is low and `rdValid` is low.
- R2: A read lowers all four chip selects and `memOeN` for the read-access cycle count (one cycle at a 20 ns clock with the fast grade), whatever `reqMask` holds, and keeps `memWeN` high. It samples `memDin` in the last access cycle. `rdValid` is high for exactly one cycle, the cycle after the last access cycle, with the sampled word on `rdData`.
- R3: A write with a non-zero mask lowers `memCsN[i]` only for the lanes whose `reqMask[i]` is 1. Lane i carries data bits 8i+7 down to 8i. `memWeN` is low in exactly the same cycles as those chip selects. `memOeN` stays high and the bus carries the request's write data.
- R4: The write-enable pulse lasts the write-pulse cycle count. That count covers the pulse-width, chip-select-to-end, address-to-end and data-setup limits, and it is one cycle at a 20 ns clock with the fast grade.
- R5: After `memWeN` rises, all chip selects stay high and the write data stays driven with an unchanged address for the recovery cycle count (one cycle at 20 ns, fast grade) before `reqReady` returns.
- R6: A write request whose mask is all zero completes in the cycle it is accepted. `reqReady` stays high, no strobe moves, and the RAM contents are unchanged.
- R7: `memDoutEn` is never high while `memOeN` is low. A write that follows a read leaves at least one cycle with `memOeN` high and the drivers off before the drivers turn on.
- R8: `memAddr` holds the accepted address for the whole request, even if `reqAddr` changes after acceptance.
- R9: `reqReady` is low from the cycle after acceptance until the request completes. With a 20 ns clock and the fast grade this is one cycle for a read and two cycles for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 32 | Write data |
| reqMask | input | 4 | Byte-lane write mask; bit i selects data bits 8i+7:8i |
| rdValid | output | 1 | One-cycle pulse marking read data |
| rdData | output | 32 | Read data |
| memAddr | output | 17 | RAM address |
| memCsN | output | 4 | Active-low chip select per byte lane |
| memWeN | output | 1 | Active-low shared write enable |
| memOeN | output | 1 | Active-low shared output enable |
| memDout | output | 32 | Data driven toward the RAM |
| memDoutEn | output | 1 | Drive enable for the data bus |
| memDin | input | 32 | Data returned from the RAM |

## Verification
The hardest case to reach is a write that arrives in the very cycle a read's data comes back. This is the only ordering in which the RAM may still be releasing the bus as the controller wants to drive it. The bench reaches it by raising a write request at the same falling edge on which `rdValid` first shows high. It then measures the number of cycles between the last cycle with output enable low and the first cycle with the drivers on. Byte-lane merging is exercised by filling a word and then overwriting alternate lanes, and a zero-mask write is checked by reading the word back unchanged.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WPULSE,
    ST_WRECOV
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // latch request fields
    logic csAll;     // every lane selected (read)
    logic csMasked;  // only masked lanes selected (write)
    logic weOn;      // write enable asserted
    logic oeOn;      // output enable asserted
    logic driveBus;  // controller drives the data bus
    logic capture;   // sample returned data
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Round a nanosecond limit up to whole clocks, never below one
  function automatic int cyclesFor(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return maxOf(c, 1);
  endfunction

  // grade 0 = fast part, anything else = slower part
  function automatic int pickNs(input int grade, input int fastNs, input int slowNs);
    return (grade == 0) ? fastNs : slowNs;
  endfunction

  function automatic int readCycles(input int periodNs, input int grade);
    int accNs, cycNs;
    accNs = pickNs(grade, 15, 20);
    cycNs = pickNs(grade, 15, 20);
    return cyclesFor(maxOf(accNs, cycNs), periodNs);
  endfunction

  function automatic int writePulseCycles(input int periodNs, input int grade);
    int pulseNs, csEndNs, addrEndNs, setupNs;
    pulseNs   = pickNs(grade, 12, 18);
    csEndNs   = pickNs(grade, 12, 18);
    addrEndNs = pickNs(grade, 12, 18);
    setupNs   = pickNs(grade, 10, 12);
    return cyclesFor(maxOf(maxOf(pulseNs, csEndNs), maxOf(addrEndNs, setupNs)), periodNs);
  endfunction

  function automatic int recoverCycles(input int periodNs, input int grade);
    int wrNs, wcNs;
    wrNs = pickNs(grade, 0, 3);
    wcNs = pickNs(grade, 15, 20);
    return maxOf(cyclesFor(wrNs, periodNs),
                 cyclesFor(wcNs, periodNs) - writePulseCycles(periodNs, grade));
  endfunction

  function automatic int turnCycles(input int periodNs, input int grade);
    return cyclesFor(pickNs(grade, 8, 12), periodNs);
  endfunction

endpackage

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int LANES         = 4,
  parameter int CLK_PERIOD_NS = 20,
  parameter int SPEED_GRADE   = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             reqReady,
  output strobe_t          strb
);

  localparam int RD_CYC   = readCycles(CLK_PERIOD_NS, SPEED_GRADE);
  localparam int WP_CYC   = writePulseCycles(CLK_PERIOD_NS, SPEED_GRADE);
  localparam int REC_CYC  = recoverCycles(CLK_PERIOD_NS, SPEED_GRADE);
  localparam int TURN_CYC = turnCycles(CLK_PERIOD_NS, SPEED_GRADE);
  localparam int MAX_CYC  = maxOf(maxOf(RD_CYC, WP_CYC), maxOf(REC_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  ctlState_t        state, stateNxt;
  logic [CNT_W-1:0] phaseCnt, phaseCntNxt;
  logic             lastRead, lastReadNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      lastRead <= 1'b0;
    end else begin
      state    <= stateNxt;
      phaseCnt <= phaseCntNxt;
      lastRead <= lastReadNxt;
    end
  end

  always_comb begin
    stateNxt    = state;
    phaseCntNxt = phaseCnt;
    lastReadNxt = lastRead;
    strb        = '0;
    unique case (state)
      ST_IDLE: begin
        strb.loadReq = reqValid;
        if (reqValid) begin
          if (!reqWrite) begin
            stateNxt    = ST_READ;
            phaseCntNxt = CNT_W'(RD_CYC - 1);
            lastReadNxt = 1'b1;
          end else if (reqMask != '0) begin
            lastReadNxt = 1'b0;
            if (lastRead) begin
              stateNxt    = ST_TURN;
              phaseCntNxt = CNT_W'(TURN_CYC - 1);
            end else begin
              stateNxt    = ST_WPULSE;
              phaseCntNxt = CNT_W'(WP_CYC - 1);
            end
          end
        end
      end
      ST_READ: begin
        strb.csAll = 1'b1;
        strb.oeOn  = 1'b1;
        if (phaseCnt == '0) begin
          strb.capture = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          phaseCntNxt = phaseCnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (phaseCnt == '0) begin
          stateNxt    = ST_WPULSE;
          phaseCntNxt = CNT_W'(WP_CYC - 1);
        end else begin
          phaseCntNxt = phaseCnt - 1'b1;
        end
      end
      ST_WPULSE: begin
        strb.csMasked = 1'b1;
        strb.weOn     = 1'b1;
        strb.driveBus = 1'b1;
        if (phaseCnt == '0) begin
          stateNxt    = ST_WRECOV;
          phaseCntNxt = CNT_W'(REC_CYC - 1);
        end else begin
          phaseCntNxt = phaseCnt - 1'b1;
        end
      end
      ST_WRECOV: begin
        strb.driveBus = 1'b1;
        if (phaseCnt == '0) begin
          stateNxt = ST_IDLE;
        end else begin
          phaseCntNxt = phaseCnt - 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [LANES-1:0]  maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      maskReg  <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
        maskReg  <= reqMask;
      end
      if (strb.capture) rdData <= memDin;
      rdValid <= strb.capture;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    assign memCsN[lane] = ~(strb.csAll | (strb.csMasked & maskReg[lane]));
  end

  assign memAddr   = addrReg;
  assign memDout   = wdataReg;
  assign memDoutEn = strb.driveBus;
  assign memWeN    = ~strb.weOn;
  assign memOeN    = ~strb.oeOn;

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 32,
  parameter int LANES         = 4,
  parameter int CLK_PERIOD_NS = 20,
  parameter int SPEED_GRADE   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  strobe_t strb;

  asram_ctrl #(
    .LANES(LANES),
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .SPEED_GRADE(SPEED_GRADE)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask(reqMask),
    .reqReady(reqReady),
    .strb(strb)
  );

  asram_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES(LANES)
  ) uDpath (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .reqAddr(reqAddr),
    .reqWdata(reqWdata),
    .reqMask(reqMask),
    .memDin(memDin),
    .memAddr(memAddr),
    .memCsN(memCsN),
    .memWeN(memWeN),
    .memOeN(memOeN),
    .memDout(memDout),
    .memDoutEn(memDoutEn),
    .rdValid(rdValid),
    .rdData(rdData)
  );

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int LANES         = 4,
  parameter int CLK_PERIOD_NS = 20,
  parameter int SPEED_GRADE   = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [LANES-1:0]  reqMask,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LANES-1:0]  memCsN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDoutEn
);

  localparam int WP_CYC = writePulseCycles(CLK_PERIOD_NS, SPEED_GRADE);

  logic [7:0] weLowCnt;
  always_ff @(posedge clk) begin
    if (!rstN) weLowCnt <= '0;
    else if (!memWeN) weLowCnt <= (weLowCnt == 8'hFF) ? weLowCnt : weLowCnt + 8'd1;
    else weLowCnt <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCsN == '1 && memWeN && memOeN && !memDoutEn));

  p_read_all_lanes_r2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memCsN == '0 && memWeN));

  p_rdvalid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  p_we_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memCsN != '1 && memOeN && memDoutEn));

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt >= 8'(WP_CYC)));

  p_recovery_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDoutEn && memCsN == '1 && $stable(memAddr)));

  p_null_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && reqMask == '0) |=> (reqReady && memCsN == '1));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> memOeN);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> $past(memOeN));

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> (reqReady || $stable(memAddr)));

  p_busy_no_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> reqReady);

endmodule

bind asram_ctl asram_ctl_chk #(
  .ADDR_W(ADDR_W),
  .LANES(LANES),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .SPEED_GRADE(SPEED_GRADE)
) uChk (
  .clk(clk),
  .rstN(rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqWrite(reqWrite),
  .reqMask(reqMask),
  .rdValid(rdValid),
  .memAddr(memAddr),
  .memCsN(memCsN),
  .memWeN(memWeN),
  .memOeN(memOeN),
  .memDoutEn(memDoutEn)
);

// File: tb/sim_asram_ctl.sv
module sim_asram_ctl;

  // Expected phase lengths at 20 ns, fast grade (ceil of ns/20, floor 1)
  localparam int EXP_RD_LAT = 2;  // one access cycle + valid cycle
  localparam int EXP_WP     = 1;  // 12 ns pulse
  localparam int EXP_REC    = 1;  // recovery
  localparam int EXP_WBUSY  = 2;  // pulse + recovery

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqMask = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic [16:0] memAddr;
  logic [3:0]  memCsN;
  logic        memWeN;
  logic        memOeN;
  logic [31:0] memDout;
  logic        memDoutEn;
  logic [31:0] memDin;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  asram_ctl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memCsN(memCsN),
    .memWeN(memWeN), .memOeN(memOeN), .memDout(memDout), .memDoutEn(memDoutEn),
    .memDin(memDin)
  );

  // Simple RAM model: four byte lanes, 256 words each
  logic [7:0] ramLane [4][256];

  initial begin
    for (int l = 0; l < 4; l++)
      for (int w = 0; w < 256; w++) ramLane[l][w] = 8'h00;
  end

  always @(negedge clk) begin
    if (!memWeN)
      for (int l = 0; l < 4; l++)
        if (!memCsN[l]) ramLane[l][memAddr[7:0]] <= memDout[8*l +: 8];
  end

  for (genvar l = 0; l < 4; l++) begin : gModel
    assign memDin[8*l +: 8] = (!memCsN[l] && memWeN && !memOeN) ? ramLane[l][memAddr[7:0]] : 8'h00;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [16:0] a, input logic [31:0] d, input logic [3:0] m,
                         output int weCyc, output int busyCyc, output int recCyc,
                         output logic [3:0] csSeen, output int faults);
    weCyc = 0; busyCyc = 0; recCyc = 0; csSeen = 4'hF; faults = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~d;
    while (!reqReady && busyCyc < 40) begin
      busyCyc++;
      if (!memWeN) begin
        weCyc++;
        csSeen = memCsN;
        if (memOeN !== 1'b1 || memDout !== d) faults++;
      end else if (weCyc > 0 && memDoutEn && memCsN == 4'hF && memDout === d) begin
        recCyc++;
      end
      if (memAddr !== a) faults++;
      if (memDoutEn && !memOeN) faults++;
      @(negedge clk);
    end
    if (memCsN !== 4'hF || memWeN !== 1'b1 || memDoutEn !== 1'b0) faults++;
  endtask

  task automatic doRead(input logic [16:0] a, input logic [3:0] m,
                        output logic [31:0] d, output int lat, output int oeCyc,
                        output logic [3:0] csOe, output logic pulseAfter, output int faults);
    lat = 1; oeCyc = 0; csOe = 4'hF; faults = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a;
    while (!rdValid && lat < 40) begin
      if (!memOeN) begin
        oeCyc++;
        csOe = memCsN;
        if (memWeN !== 1'b1) faults++;
      end
      if (memAddr !== a) faults++;
      if (reqReady) faults++;
      @(negedge clk);
      lat++;
    end
    d = rdData;
    if (!reqReady) faults++;
    @(negedge clk);
    pulseAfter = rdValid;
  endtask

  task automatic tReset();
    check(reqReady === 1'b1, "R1", "ready after reset", 32'(reqReady), 32'd1);
    check(memCsN === 4'hF, "R1", "chip selects after reset", 32'(memCsN), 32'hF);
    check(memWeN === 1'b1 && memOeN === 1'b1, "R1", "we/oe after reset",
          {30'd0, memWeN, memOeN}, 32'd3);
    check(memDoutEn === 1'b0 && rdValid === 1'b0, "R1", "drive/rdValid after reset",
          {30'd0, memDoutEn, rdValid}, 32'd0);
  endtask

  task automatic tFullWord();
    int we, busy, rec, f, lat, oe;
    logic [3:0] cs, csO;
    logic [31:0] d;
    logic pa;
    doWrite(17'h1FF33, 32'hA5A5_1234, 4'hF, we, busy, rec, cs, f);
    check(cs === 4'h0, "R3", "full write lanes", 32'(cs), 32'h0);
    check(we == EXP_WP, "R4", "write pulse cycles", 32'(we), 32'(EXP_WP));
    check(rec == EXP_REC, "R5", "recovery cycles", 32'(rec), 32'(EXP_REC));
    check(f == 0, "R8", "address/data held during write", 32'(f), 32'd0);
    check(busy == EXP_WBUSY, "R9", "write busy cycles", 32'(busy), 32'(EXP_WBUSY));
    doRead(17'h1FF33, 4'hF, d, lat, oe, csO, pa, f);
    check(d === 32'hA5A5_1234, "R2", "read back full word", d, 32'hA5A5_1234);
    check(lat == EXP_RD_LAT, "R2", "rdValid latency", 32'(lat), 32'(EXP_RD_LAT));
    check(pa === 1'b0, "R2", "rdValid single cycle", 32'(pa), 32'd0);
    check(oe == 1 && csO === 4'h0, "R2", "oe cycles and lanes", {oe[27:0], csO}, 32'h10);
    check(f == 0, "R9", "read busy and address hold", 32'(f), 32'd0);
  endtask

  task automatic tByteLanes();
    int we, busy, rec, f, lat, oe;
    logic [3:0] cs, csO;
    logic [31:0] d;
    logic pa;
    doWrite(17'h00020, 32'hFFFF_FFFF, 4'hF, we, busy, rec, cs, f);
    doWrite(17'h00020, 32'h1122_3344, 4'b0101, we, busy, rec, cs, f);
    check(cs === 4'b1010, "R3", "masked lanes selected", 32'(cs), 32'hA);
    check(f == 0, "R3", "oe high and data driven in pulse", 32'(f), 32'd0);
    doRead(17'h00020, 4'hF, d, lat, oe, csO, pa, f);
    check(d === 32'hFF22_FF44, "R3", "byte merge", d, 32'hFF22_FF44);
    doWrite(17'h00021, 32'hDEAD_BEEF, 4'b1000, we, busy, rec, cs, f);
    check(cs === 4'b0111, "R3", "top lane only", 32'(cs), 32'h7);
  endtask

  task automatic tNullWrite();
    int we, busy, rec, f, lat, oe;
    logic [3:0] cs, csO;
    logic [31:0] d;
    logic pa;
    doWrite(17'h00020, 32'h0000_0000, 4'b0000, we, busy, rec, cs, f);
    check(we == 0 && busy == 0, "R6", "no strobe, no busy", {we[15:0], busy[15:0]}, 32'd0);
    check(f == 0, "R6", "strobes quiet after null write", 32'(f), 32'd0);
    doRead(17'h00020, 4'hF, d, lat, oe, csO, pa, f);
    check(d === 32'hFF22_FF44, "R6", "contents unchanged", d, 32'hFF22_FF44);
  endtask

  task automatic tReadIgnoresMask();
    int lat, oe, f;
    logic [3:0] csO;
    logic [31:0] d;
    logic pa;
    doRead(17'h1FF33, 4'b0000, d, lat, oe, csO, pa, f);
    check(csO === 4'h0, "R2", "read selects all lanes with zero mask", 32'(csO), 32'h0);
    check(d === 32'hA5A5_1234, "R2", "read data with zero mask", d, 32'hA5A5_1234);
  endtask

  task automatic tReadThenWrite();
    int cyc, lastOe, firstDrive, f, lat, oe;
    logic [31:0] rd, d;
    logic [3:0] csO;
    logic pa;
    cyc = 0; lastOe = -1; firstDrive = -1; f = 0; rd = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 17'h00021; reqMask = 4'hF;
    @(negedge clk);
    reqValid = 1'b0;
    while (cyc < 30) begin
      if (!memOeN) lastOe = cyc;
      if (memDoutEn && firstDrive < 0) firstDrive = cyc;
      if (memDoutEn && !memOeN) f++;
      if (rdValid) begin
        rd = rdData;
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 17'h00040;
        reqWdata = 32'h0BAD_F00D; reqMask = 4'hF;
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (firstDrive >= 0 && reqReady) break;
    end
    reqValid = 1'b0;
    check(rd === 32'hDEAD_BE00 || rd === 32'hDE00_0000, "R2", "read before write",
          rd, 32'hDE00_0000);
    check(f == 0, "R7", "no drive while oe low", 32'(f), 32'd0);
    check(firstDrive - lastOe >= 2, "R7", "idle gap before drive",
          32'(firstDrive - lastOe - 1), 32'd1);
    doRead(17'h00040, 4'hF, d, lat, oe, csO, pa, f);
    check(d === 32'h0BAD_F00D, "R7", "write after read lands", d, 32'h0BAD_F00D);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFullWord();
    tByteLanes();
    tNullWrite();
    tReadIgnoresMask();
    tReadThenWrite();
    repeat (3) @(negedge clk);
    tReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule